// File: doc/BRIEF.md
# Event Ring Producer

This block is the producing side of a circular event queue in system memory. Other logic posts event requests, each with a type code, a completion code and a 64-bit parameter. The block turns each accepted request into one 128-bit record and writes it through a single memory write port at the current enqueue slot. The ring is made of one or two segments, each given by a base address and a slot count. Consumer software tells the block how far it has read by writing a dequeue-pointer register.

Each record carries the producer cycle state. Software compares that bit with its own expected value to tell fresh records from stale ones, so no count register is needed. The cycle state begins at 1 and inverts each time enqueue wraps from the end of the last segment back to the start of the first. One slot is always held back. When a request arrives and only that reserve remains, the block writes a ring-full error record instead of the request. It then refuses new requests until software moves the dequeue position.

Top module: `event_ring_producer`

## Requirements
- R1: After reset, and in the cycle after a one-cycle pulse on `tbl_wr`, the enqueue slot is the first slot of segment 0, `cycle_state` is 1 and the ring is not blocked.
- R2: A request is accepted in a cycle where `post_valid` and `post_ready` are both high. Each accepted request produces exactly one memory write, with `mem_we` high in the following cycle only.
- R3: Records are 16 bytes. The write address is the segment base plus 16 times the slot index. After the last slot of segment 0, enqueue moves to the base of segment 1 when two segments are active. After the last slot of the last active segment, it returns to the base of segment 0.
- R4: Record layout: bits [63:0] parameter, [71:64] completion code, [77:72] type code, [96] the cycle state at the time of the write, and all other bits 0. The cycle state inverts on every wrap back to segment 0.
- R5: `seg_count` of 0 disables the ring: `post_ready` stays low and no write occurs. A value of 3 behaves as 2.
- R6: A dequeue-register write loads address bits [AW-1:4] and the segment index from bits [2:0]. Bit 3 is ignored.
- R7: `ring_not_empty` is high exactly when the enqueue slot differs from the stored dequeue position. It is updated in the cycle after an enqueue or a dequeue-register write.
- R8: The ring is full for a new request when two slot advances from the enqueue slot land on the dequeue slot. In that case the accepted request is replaced by a record with type 32, completion code 21 and parameter 0. The ring then becomes blocked.
- R9: While blocked, `post_ready` is low. Only a dequeue-register write that changes the stored position, or a `tbl_wr` pulse, clears the block. Rewriting the same position does not clear it.
- R10: `post_ready` is low in any cycle where `deq_wr` or `tbl_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_count | input | 2 | Number of active segments (0 = ring off) |
| seg0_base | input | AW | Byte base of segment 0, 16-byte aligned |
| seg0_size | input | SW | Slot count of segment 0 |
| seg1_base | input | AW | Byte base of segment 1, 16-byte aligned |
| seg1_size | input | SW | Slot count of segment 1 |
| tbl_wr | input | 1 | Segment-table base written; restarts the ring |
| deq_wr | input | 1 | Dequeue-register write strobe |
| deq_ptr | input | AW | Dequeue value: address bits [AW-1:4], segment index [2:0] |
| post_valid | input | 1 | Event request present |
| post_type | input | 6 | Event type code (32, 33, 34, 40) |
| post_code | input | 8 | Completion code |
| post_param | input | 64 | Event parameter |
| post_ready | output | 1 | Request can be accepted this cycle |
| mem_we | output | 1 | Record write strobe |
| mem_addr | output | AW | Record byte address |
| mem_data | output | 128 | Record contents |
| cycle_state | output | 1 | Producer cycle state |
| ring_not_empty | output | 1 | Enqueue differs from dequeue position |

## Verification
`post_ready` is combinational, so the bench samples it 1 ns after driving the request at a falling edge, in the same cycle. The record write passes through one register. Its strobe, address and data are therefore sampled at the falling edge after the accepting rising edge. `cycle_state`, `ring_not_empty` and the blocked state all come from registers that update on the accepting edge or the dequeue-write edge, so they are checked at that same falling edge. The bench computes every expected slot, cycle bit and full decision from a global slot counter taken modulo the ring size.

// File: rtl/event_ring_pkg.sv
package event_ring_pkg;
  localparam int REC_W   = 128;
  localparam int PARAM_W = 64;
  localparam int TYPE_W  = 6;
  localparam int CODE_W  = 8;

  typedef enum logic [TYPE_W-1:0] {
    EVT_XFER  = 6'd32,
    EVT_CMD   = 6'd33,
    EVT_PORT  = 6'd34,
    EVT_SETUP = 6'd40
  } evt_type_e;

  localparam logic [CODE_W-1:0] CC_RING_FULL = 8'd21;

  // Record: [63:0] param, [71:64] code, [77:72] type, [96] cycle
  function automatic logic [REC_W-1:0] pack_record(
    input logic [TYPE_W-1:0]  typ,
    input logic [CODE_W-1:0]  code,
    input logic [PARAM_W-1:0] prm,
    input logic               cyc);
    logic [REC_W-1:0] r;
    r          = '0;
    r[63:0]    = prm;
    r[71:64]   = code;
    r[77:72]   = typ;
    r[96]      = cyc;
    return r;
  endfunction
endpackage

// File: rtl/event_ring_enq.sv
module event_ring_enq #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          step,
  input  logic          two_seg,
  input  logic [SW-1:0] size0,
  input  logic [SW-1:0] size1,
  output logic          seg_q,
  output logic [SW-1:0] off_q,
  output logic          pcs_q,
  output logic          nxt2_seg,
  output logic [SW-1:0] nxt2_off,
  output logic          wrap_evt
);
  typedef struct packed {
    logic          seg;
    logic [SW-1:0] off;
    logic          wrap;
  } pos_t;

  // one slot forward; wrap set when returning to segment 0
  function automatic pos_t adv(input logic seg, input logic [SW-1:0] off,
                               input logic two, input logic [SW-1:0] s0,
                               input logic [SW-1:0] s1);
    pos_t r;
    logic [SW-1:0] lim;
    lim = seg ? s1 : s0;
    if (off + SW'(1) >= lim) begin
      r.off = '0;
      if (two && !seg) begin
        r.seg  = 1'b1;
        r.wrap = 1'b0;
      end else begin
        r.seg  = 1'b0;
        r.wrap = 1'b1;
      end
    end else begin
      r.off  = off + SW'(1);
      r.seg  = seg;
      r.wrap = 1'b0;
    end
    return r;
  endfunction

  pos_t n1, n2;
  assign n1       = adv(seg_q, off_q, two_seg, size0, size1);
  assign n2       = adv(n1.seg, n1.off, two_seg, size0, size1);
  assign nxt2_seg = n2.seg;
  assign nxt2_off = n2.off;
  assign wrap_evt = step && n1.wrap;

  logic unused_n2;
  assign unused_n2 = n2.wrap;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      seg_q <= 1'b0;
      off_q <= '0;
      pcs_q <= 1'b1;
    end else if (step) begin
      seg_q <= n1.seg;
      off_q <= n1.off;
      if (n1.wrap) pcs_q <= ~pcs_q;
    end
  end

  p_restart_home_r1: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!seg_q && off_q == '0 && pcs_q));
  p_cycle_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !restart) |=> (pcs_q != $past(pcs_q)));
  p_cycle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_evt && !restart) |=> $stable(pcs_q));
endmodule

// File: rtl/event_ring_deq.sv
module event_ring_deq #(
  parameter int LW = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [LW-1:0] line_in,
  input  logic [2:0]    seg_in,
  output logic [LW-1:0] line_q,
  output logic [2:0]    seg_q,
  output logic          moved
);
  assign moved = wr && ((line_in != line_q) || (seg_in != seg_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= '0;
      seg_q  <= '0;
    end else if (wr) begin
      line_q <= line_in;
      seg_q  <= seg_in;
    end
  end

  p_deq_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (line_q == $past(line_in) && seg_q == $past(seg_in)));
endmodule

// File: rtl/event_ring_occ.sv
module event_ring_occ #(
  parameter int LW = 28
) (
  input  logic [LW-1:0] enq_line,
  input  logic [2:0]    enq_seg,
  input  logic [LW-1:0] far_line,
  input  logic [2:0]    far_seg,
  input  logic [LW-1:0] deq_line,
  input  logic [2:0]    deq_seg,
  output logic          empty,
  output logic          near_full
);
  assign empty     = (enq_line == deq_line) && (enq_seg == deq_seg);
  assign near_full = (far_line == deq_line) && (far_seg == deq_seg);
endmodule

// File: rtl/event_ring_producer.sv
module event_ring_producer
  import event_ring_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         seg_count,
  input  logic [AW-1:0]      seg0_base,
  input  logic [SW-1:0]      seg0_size,
  input  logic [AW-1:0]      seg1_base,
  input  logic [SW-1:0]      seg1_size,
  input  logic               tbl_wr,
  input  logic               deq_wr,
  input  logic [AW-1:0]      deq_ptr,
  input  logic               post_valid,
  input  logic [TYPE_W-1:0]  post_type,
  input  logic [CODE_W-1:0]  post_code,
  input  logic [PARAM_W-1:0] post_param,
  output logic               post_ready,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [REC_W-1:0]   mem_data,
  output logic               cycle_state,
  output logic               ring_not_empty
);
  localparam int LW = AW - 4;

  function automatic logic [LW-1:0] line_of(input logic seg,
                                            input logic [SW-1:0] off,
                                            input logic [AW-1:0] b0,
                                            input logic [AW-1:0] b1);
    return (seg ? b1[AW-1:4] : b0[AW-1:4]) + LW'(off);
  endfunction

  logic          ring_on, two_seg, accept, blocked_q;
  logic          enq_seg, far_seg, pcs, wrap_evt;
  logic [SW-1:0] enq_off, far_off;
  logic [LW-1:0] enq_line, far_line, deq_line;
  logic [2:0]    deq_seg;
  logic          deq_moved, empty, near_full;

  assign ring_on    = |seg_count;
  assign two_seg    = seg_count[1];
  assign post_ready = ring_on && !blocked_q && !deq_wr && !tbl_wr;
  assign accept     = post_valid && post_ready;

  logic unused_bits;
  assign unused_bits = ^{seg0_base[3:0], seg1_base[3:0], deq_ptr[3], wrap_evt};

  event_ring_enq #(.SW(SW)) u_enq (
    .clk(clk), .rst_n(rst_n), .restart(tbl_wr), .step(accept),
    .two_seg(two_seg), .size0(seg0_size), .size1(seg1_size),
    .seg_q(enq_seg), .off_q(enq_off), .pcs_q(pcs),
    .nxt2_seg(far_seg), .nxt2_off(far_off), .wrap_evt(wrap_evt)
  );

  event_ring_deq #(.LW(LW)) u_deq (
    .clk(clk), .rst_n(rst_n), .wr(deq_wr),
    .line_in(deq_ptr[AW-1:4]), .seg_in(deq_ptr[2:0]),
    .line_q(deq_line), .seg_q(deq_seg), .moved(deq_moved)
  );

  assign enq_line = line_of(enq_seg, enq_off, seg0_base, seg1_base);
  assign far_line = line_of(far_seg, far_off, seg0_base, seg1_base);

  event_ring_occ #(.LW(LW)) u_occ (
    .enq_line(enq_line), .enq_seg({2'b00, enq_seg}),
    .far_line(far_line), .far_seg({2'b00, far_seg}),
    .deq_line(deq_line), .deq_seg(deq_seg),
    .empty(empty), .near_full(near_full)
  );

  assign cycle_state    = pcs;
  assign ring_not_empty = !empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
      blocked_q <= 1'b0;
    end else begin
      mem_we <= accept;
      if (accept) begin
        mem_addr <= {enq_line, 4'b0000};
        mem_data <= near_full ? pack_record(EVT_XFER, CC_RING_FULL, '0, pcs)
                              : pack_record(post_type, post_code, post_param, pcs);
      end
      if (tbl_wr || deq_moved)      blocked_q <= 1'b0;
      else if (accept && near_full) blocked_q <= 1'b1;
    end
  end

  p_write_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> mem_we);
  p_no_stray_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !mem_we);
  p_full_record_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && near_full) |=> (mem_data[71:64] == CC_RING_FULL && !post_ready));
  p_block_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked_q && !deq_moved && !tbl_wr) |=> blocked_q);
endmodule

// File: tb/event_ring_producer_tb.sv
`timescale 1ns/1ps
module event_ring_producer_tb;
  localparam int AW = 32;
  localparam int SW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n = 1'b0;
  logic [1:0]     seg_count = 2'd2;
  logic [AW-1:0]  seg0_base = 32'h0000_1000, seg1_base = 32'h0000_8000;
  logic [SW-1:0]  seg0_size = 16'd3, seg1_size = 16'd2;
  logic           tbl_wr = 1'b0, deq_wr = 1'b0;
  logic [AW-1:0]  deq_ptr = '0;
  logic           post_valid = 1'b0;
  logic [5:0]     post_type = '0;
  logic [7:0]     post_code = '0;
  logic [63:0]    post_param = '0;
  logic           post_ready, mem_we, cycle_state, ring_not_empty;
  logic [AW-1:0]  mem_addr;
  logic [127:0]   mem_data;

  event_ring_producer #(.AW(AW), .SW(SW)) u_dut (.*);

  int checks = 0, fails = 0;
  int s0 = 3, s1 = 2, nsg = 2, rs = 5, g = 0, dpos = -1;
  bit blk = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] slot_addr(input int p);
    if (p < s0) return seg0_base + AW'(p * 16);
    return seg1_base + AW'((p - s0) * 16);
  endfunction

  function automatic bit exp_pcs();
    return ((g / rs) % 2) == 0;
  endfunction

  task automatic post(input logic [5:0] t, input logic [7:0] c, input logic [63:0] p);
    bit rdy, full, pc;
    logic [AW-1:0] ea;
    logic [127:0] er;
    string rq;
    @(negedge clk);
    post_valid = 1'b1; post_type = t; post_code = c; post_param = p;
    #1;
    rdy = (nsg != 0) && !blk;
    rq  = (nsg == 0) ? "R5" : (blk ? "R9" : "R2");
    chk(post_ready == rdy, rq, "post_ready", post_ready, rdy);
    full = 1'b0; pc = 1'b0; ea = '0;
    if (rdy) begin
      full = ((g + 2) % rs) == dpos;
      pc   = exp_pcs();
      ea   = slot_addr(g % rs);
      er   = full ? {31'd0, pc, 18'd0, 6'd32, 8'd21, 64'd0}
                  : {31'd0, pc, 18'd0, t, c, p};
    end else er = '0;
    @(posedge clk);
    @(negedge clk);
    post_valid = 1'b0;
    if (rdy) begin
      chk(mem_we == 1'b1, "R2", "mem_we", mem_we, 1);
      chk(mem_addr == ea, "R3", "mem_addr", mem_addr, ea);
      chk(mem_data == er, full ? "R8" : "R4", "mem_data", mem_data, er);
      g++;
      if (full) blk = 1'b1;
    end else begin
      chk(mem_we == 1'b0, rq, "mem_we idle", mem_we, 0);
    end
    if (nsg != 0) begin
      chk(ring_not_empty == ((g % rs) != dpos), "R7", "ring_not_empty",
          ring_not_empty, ((g % rs) != dpos));
      chk(cycle_state == exp_pcs(), "R4", "cycle_state", cycle_state, exp_pcs());
    end
  endtask

  task automatic deq_set(input int p, input bit junk3);
    @(negedge clk);
    deq_wr  = 1'b1;
    deq_ptr = slot_addr(p) | AW'(p < s0 ? 0 : 1) | (junk3 ? AW'(8) : AW'(0));
    #1;
    chk(post_ready == 1'b0, "R10", "post_ready during deq write", post_ready, 0);
    @(posedge clk);
    @(negedge clk);
    deq_wr = 1'b0;
    if (p != dpos) blk = 1'b0;
    dpos = p;
    chk(ring_not_empty == ((g % rs) != dpos), junk3 ? "R6" : "R7", "ring_not_empty after deq",
        ring_not_empty, ((g % rs) != dpos));
  endtask

  task automatic restart_cfg(input int a, input int b, input int n);
    seg_count = n[1:0]; seg0_size = SW'(a); seg1_size = SW'(b);
    @(negedge clk);
    tbl_wr = 1'b1;
    #1;
    chk(post_ready == 1'b0, "R10", "post_ready during restart", post_ready, 0);
    @(posedge clk);
    @(negedge clk);
    tbl_wr = 1'b0;
    s0 = a; s1 = b; nsg = (n > 2) ? 2 : n;
    rs = s0 + ((nsg >= 2) ? s1 : 0);
    g = 0; blk = 1'b0;
    chk(cycle_state == 1'b1, "R1", "cycle_state after restart", cycle_state, 1);
  endtask

  task automatic run_cfg(input int a, input int b, input int n);
    restart_cfg(a, b, n);
    deq_set(0, 1'b0);
    for (int k = 0; k < 2 * rs + 2; k++) begin
      post(6'(32 + (k % 3)), 8'(k), {32'(k), 32'hA5A5_0000 | 32'(a)});
      deq_set(g % rs, 1'b0);
    end
    for (int k = 0; k <= rs; k++) post(6'd40, 8'd1, 64'(k * 7 + 1));
    deq_set(dpos, 1'b1);
    post(6'd33, 8'd1, 64'd99);
    deq_set((dpos + 1) % rs, 1'b0);
    post(6'd34, 8'd1, 64'd77);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cycle_state == 1'b1, "R1", "cycle_state at reset", cycle_state, 1);
    chk(mem_we == 1'b0, "R1", "mem_we at reset", mem_we, 0);
    chk(post_ready == 1'b1, "R1", "post_ready at reset", post_ready, 1);
    deq_set(0, 1'b0);
    post(6'd32, 8'd1, 64'h1234);
    run_cfg(3, 2, 2);
    run_cfg(4, 3, 2);
    run_cfg(5, 1, 1);
    run_cfg(2, 2, 3);
    restart_cfg(3, 2, 0);
    post(6'd33, 8'd1, 64'd5);
    run_cfg(3, 3, 2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule